// File: doc/BRIEF.md
# Host Interrupt Register Bank

This block gathers one-cycle event pulses from on-chip logic into a latched status vector and exposes it to host software through a small register bank. Software can choose which sources may raise the host interrupt line through a mask. It can update that mask in one write, or bit by bit through set and clear ports that leave other bits alone. It can inspect the status without disturbing it or with a read that empties it, and it can retire individual events by writing ones to an acknowledge port.

The single host line is registered. Two configuration bits set its behaviour: one enables it, and one inverts its polarity so that it is active low. The register port is a plain synchronous read/write interface. Every access is accepted in the cycle it is presented. There is no back-pressure, and read data is returned one cycle later.

Register map (3-bit address): 0 mask (read/write), 1 mask set (write only), 2 mask clear (write only), 3 status without side effects (read only), 4 status cleared by read (read only), 5 acknowledge (write only), 6 line configuration (read/write; bit 0 enable, bit 1 active low). Sources that exist are bits 0–10, 14, 16 and 17. All other bits are reserved.

Top module: `hint_regbank`

## Requirements
- R1: After reset the mask is 0x0000_0001, the status is zero, the configuration is zero, reg_rdata is zero and host_irq is 0.
- R2: A one-cycle pulse on an implemented src_pulse bit sets that status bit at the next edge whatever its mask bit is. Reserved bits (all except 0–10, 14, 16, 17) never set and always read as zero in the mask and in the status.
- R3: A write to address 0 replaces the mask with the written value, restricted to implemented bits.
- R4: A write to address 1 ORs the written ones into the mask. Bits written as zero keep their value.
- R5: A write to address 2 clears the mask bits written as one. Bits written as zero keep their value.
- R6: A read of address 3 returns the status and leaves it unchanged.
- R7: A read of address 4 returns the status and clears every status bit at the same edge.
- R8: A write to address 5 clears the status bits written as one, as seen in both status views. Bits written as zero keep their value.
- R9: When a source pulse and a clear (address 4 read or address 5 acknowledge) hit the same bit in the same cycle, the bit is set after that edge.
- R10: host_irq is a register. At each edge it takes (cfg bit 0 AND any bit of status AND NOT mask) XOR cfg bit 1, using the values held before that edge.
- R11: reg_rdata is a register, loaded only in a cycle with reg_rd high, and holds its value otherwise. Reads return the values held before that edge. Addresses 1, 2, 5 and 7 read as zero. Configuration reads return bits 1:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_pulse | input | 32 | One-cycle event pulses, one bit per source |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| host_irq | output | 1 | Host interrupt line |

## Verification
Each result has its own latency.
- A status change appears one edge after the pulse or clear that causes it, so a read issued in the next cycle sees it.
- Read data appears one edge after the read strobe.
- The host line follows the status one edge later than that, so it moves two edges after a source pulse.
- A configuration or mask write affects the line at the second edge after the write.

The bench keeps a behavioural model that advances on each rising edge from the same inputs. It compares reg_rdata and host_irq with the model at every falling edge, so each result is checked in the exact cycle it is due and in every other cycle as well.

// File: rtl/hint_pkg.sv
package hint_pkg;
  typedef enum logic [2:0] {
    A_MASK  = 3'd0,
    A_MSET  = 3'd1,
    A_MCLR  = 3'd2,
    A_STAT  = 3'd3,
    A_STATC = 3'd4,
    A_ACK   = 3'd5,
    A_CFG   = 3'd6
  } hint_addr_e;

  localparam int CFG_EN_BIT  = 0;
  localparam int CFG_LOW_BIT = 1;
  localparam int CFG_W       = 2;
endpackage

// File: rtl/hint_mask.sv
module hint_mask #(
  parameter int          DW   = 32,
  parameter logic [DW-1:0] IMPL = '1,
  parameter logic [DW-1:0] RSTV = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_full,
  input  logic          wr_set,
  input  logic          wr_clr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask
);
  logic [DW-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= RSTV & IMPL;
    else if (wr_full) mask_q <= wdata & IMPL;
    else if (wr_set)  mask_q <= mask_q | (wdata & IMPL);
    else if (wr_clr)  mask_q <= mask_q & ~wdata;
  end

  assign mask = mask_q;

  // R4: set port leaves every written one set
  p_set_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask & $past(wdata & IMPL)) == $past(wdata & IMPL)));
  // R4: zero bits of a set write keep their value
  p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((mask & ~$past(wdata)) == ($past(mask) & ~$past(wdata))));
  // R5: clear port empties every written one
  p_clr_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((mask & $past(wdata)) == '0));
endmodule

// File: rtl/hint_status.sv
module hint_status #(
  parameter int            DW   = 32,
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic          ack_we,
  input  logic [DW-1:0] ack_data,
  input  logic          cor_rd,
  output logic [DW-1:0] status
);
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] stat_q;

  assign clr_vec = (ack_we ? ack_data : '0) | (cor_rd ? '1 : '0);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (IMPL[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (!rst_n)      stat_q[i] <= 1'b0;
        else if (src[i]) stat_q[i] <= 1'b1;
        else if (clr_vec[i]) stat_q[i] <= 1'b0;
      end
    end else begin : g_rsvd
      assign stat_q[i] = 1'b0;
    end
  end

  assign status = stat_q;

  // R2/R9: every implemented pulse is held after the edge, clear or not
  p_pulse_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src & IMPL)) |=> ((status & $past(src & IMPL)) == $past(src & IMPL)));
  // R7: read of the clearing view without a pulse empties status
  p_cor_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_rd && !(|src)) |=> (status == '0));
  // R8: acknowledged bits drop when no pulse arrives
  p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !(|src)) |=> ((status & $past(ack_data)) == '0));
  // R6: with no pulse and no clear, status holds
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|src) && !ack_we && !cor_rd) |=> $stable(status));
endmodule

// File: rtl/hint_line.sv
module hint_line #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] mask,
  input  logic          en,
  input  logic          act_low,
  output logic          line
);
  logic live;
  logic line_q;

  assign live = en & (|(status & ~mask));

  always_ff @(posedge clk) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= live ^ act_low;
  end

  assign line = line_q;

  // R10: nothing unmasked pending, active high -> line low next cycle
  p_quiet_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (((status & ~mask) == '0) && !act_low) |=> !line);
  // R10: disabled and active low -> line parked high next cycle
  p_parked_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && act_low) |=> line);
endmodule

// File: rtl/hint_regbank.sv
module hint_regbank
  import hint_pkg::*;
#(
  parameter int            DW       = 32,
  parameter int            AW       = 3,
  parameter logic [DW-1:0] SRC_IMPL = 32'h0003_47FF,
  parameter logic [DW-1:0] MASK_RST = 32'h0000_0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src_pulse,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          host_irq
);
  localparam int PAD_W = DW - CFG_W;

  logic [DW-1:0]    mask;
  logic [DW-1:0]    status;
  logic [CFG_W-1:0] cfg_q;
  logic [DW-1:0]    rd_mux;
  logic [DW-1:0]    rdata_q;

  logic wr_full, wr_set, wr_clr, ack_we, cor_rd, cfg_we;

  assign wr_full = reg_wr && (reg_addr == A_MASK);
  assign wr_set  = reg_wr && (reg_addr == A_MSET);
  assign wr_clr  = reg_wr && (reg_addr == A_MCLR);
  assign ack_we  = reg_wr && (reg_addr == A_ACK);
  assign cfg_we  = reg_wr && (reg_addr == A_CFG);
  assign cor_rd  = reg_rd && (reg_addr == A_STATC);

  hint_mask #(.DW(DW), .IMPL(SRC_IMPL), .RSTV(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_full(wr_full), .wr_set(wr_set),
    .wr_clr(wr_clr), .wdata(reg_wdata), .mask(mask)
  );

  hint_status #(.DW(DW), .IMPL(SRC_IMPL)) u_status (
    .clk(clk), .rst_n(rst_n), .src(src_pulse), .ack_we(ack_we),
    .ack_data(reg_wdata), .cor_rd(cor_rd), .status(status)
  );

  hint_line #(.DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .status(status), .mask(mask),
    .en(cfg_q[CFG_EN_BIT]), .act_low(cfg_q[CFG_LOW_BIT]), .line(host_irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= reg_wdata[CFG_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_MASK:  rd_mux = mask;
      A_STAT:  rd_mux = status;
      A_STATC: rd_mux = status;
      A_CFG:   rd_mux = {{PAD_W{1'b0}}, cfg_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  // R2: reserved bits never show on the read port
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata & ~SRC_IMPL) == '0) || ($past(reg_addr) == A_CFG));
  // R11: read data holds when no read strobe
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
  // R6: status read returns what the status held
  p_nd_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == A_STAT) |=> (reg_rdata == $past(status)));
endmodule

// File: tb/hint_regbank_tb_top.sv
module hint_regbank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_pulse = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R1";
  bit done = 0;

  // model state
  logic [31:0] m_mask, m_stat, m_rdata, impl;
  logic [1:0]  m_cfg;
  logic        m_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  hint_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  initial begin
    impl = '0;
    for (int b = 0; b <= 10; b++) impl[b] = 1'b1;
    impl[14] = 1'b1; impl[16] = 1'b1; impl[17] = 1'b1;
  end

  // reference model, advanced each rising edge
  always @(posedge clk) begin
    logic [31:0] clr, rv;
    logic        nl;
    if (!rst_n) begin
      m_mask = 32'h1; m_stat = '0; m_cfg = '0; m_rdata = '0; m_line = 1'b0;
    end else begin
      rv = 32'h0;
      if (reg_addr == 3'd0) rv = m_mask;
      else if (reg_addr == 3'd3 || reg_addr == 3'd4) rv = m_stat;
      else if (reg_addr == 3'd6) rv = {30'b0, m_cfg};
      nl = (m_cfg[0] && ((m_stat & ~m_mask) != 0)) ^ m_cfg[1];
      clr = '0;
      if (reg_wr && reg_addr == 3'd5) clr = reg_wdata;
      if (reg_rd && reg_addr == 3'd4) clr = '1;
      m_stat = ((m_stat & ~clr) | src_pulse) & impl;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_mask = reg_wdata & impl;
          3'd1: m_mask = m_mask | (reg_wdata & impl);
          3'd2: m_mask = m_mask & ~reg_wdata;
          3'd6: m_cfg  = reg_wdata[1:0];
          default: ;
        endcase
      end
      if (reg_rd) m_rdata = rv;
      m_line = nl;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (m_mask !== 32'hx && !done) begin
      n_chk++;
      if (reg_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s reg_rdata actual=%h expected=%h t=%0t", cur_tag, reg_rdata, m_rdata, $time);
      end
      n_chk++;
      if (host_irq !== m_line) begin
        n_bad++;
        $display("FAIL %s host_irq actual=%b expected=%b t=%0t", cur_tag, host_irq, m_line, $time);
      end
    end
  end

  task automatic step(input string tag, input logic [31:0] src, input logic wr,
                      input logic rd, input logic [2:0] a, input logic [31:0] d);
    cur_tag = tag;
    src_pulse = src; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    @(negedge clk);
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag, '0, 1'b0, 1'b0, 3'd0, '0);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [31:0] d);
    step(tag, '0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, '0, 1'b0, 1'b1, a, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    @(negedge clk); idle("R1", 4);
    // R1 explicit reset values
    n_chk++;
    if (reg_rdata !== 32'h0 || host_irq !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset actual=%h/%b expected=0/0", reg_rdata, host_irq);
    end
    rst_n = 1'b1;
    idle("R1", 1);
    rd("R1", 3'd0); idle("R1", 1);
    n_chk++;
    if (reg_rdata !== 32'h1) begin
      n_bad++;
      $display("FAIL R1 mask reset actual=%h expected=00000001", reg_rdata);
    end
    rd("R1", 3'd6); rd("R1", 3'd3);
    wr("R10", 3'd6, 32'h1);
    step("R2", 32'h1, 1'b0, 1'b0, 3'd0, '0);      // masked source
    idle("R2", 2);
    rd("R6", 3'd3); rd("R6", 3'd3);
    step("R10", 32'h2, 1'b0, 1'b0, 3'd0, '0);     // unmasked source
    idle("R10", 3);
    rd("R6", 3'd3);
    wr("R8", 3'd5, 32'h2);
    idle("R8", 2); rd("R8", 3'd3); rd("R8", 3'd4 - 3'd1);
    wr("R4", 3'd1, 32'h0000_0002);
    rd("R4", 3'd0);
    step("R4", 32'h2, 1'b0, 1'b0, 3'd0, '0);
    idle("R4", 2);
    wr("R5", 3'd2, 32'h0000_0003);
    idle("R5", 2); rd("R5", 3'd0);
    rd("R7", 3'd4); idle("R7", 2); rd("R7", 3'd3);
    step("R2", 32'h8000_1000, 1'b0, 1'b0, 3'd0, '0); // reserved sources
    rd("R2", 3'd3); idle("R2", 1);
    wr("R3", 3'd0, 32'hFFFF_FFFF); rd("R3", 3'd0);
    wr("R3", 3'd0, 32'h0000_0000); rd("R3", 3'd0);
    step("R9", 32'h400, 1'b0, 1'b0, 3'd0, '0);
    step("R9", 32'h400, 1'b0, 1'b1, 3'd4, '0);   // pulse vs clear-on-read
    rd("R9", 3'd3); idle("R9", 1);
    step("R9", 32'h400, 1'b1, 1'b0, 3'd5, 32'h400); // pulse vs ack
    rd("R9", 3'd3);
    wr("R8", 3'd5, 32'h0000_0000); rd("R8", 3'd3);
    wr("R10", 3'd6, 32'h3); idle("R10", 2);
    rd("R7", 3'd4); idle("R10", 2);
    wr("R10", 3'd6, 32'h2); idle("R10", 2);
    wr("R10", 3'd6, 32'h1);
    rd("R11", 3'd1); rd("R11", 3'd2); rd("R11", 3'd5); rd("R11", 3'd7);
    step("R11", '0, 1'b1, 1'b1, 3'd0, 32'h0000_00F0);
    rd("R11", 3'd0); idle("R11", 2);
    lf = 32'hACE1_1234;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      step("R10", lf & {32{lf[5]}}, lf[7], ~lf[7] & lf[9], lf[12:10], {lf[15:0], lf[31:16]});
    end
    idle("R10", 3);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule